// File: doc/BRIEF.md
# 24-bit SPI Command Front End

This block is the serial command port of a dual programmable-resistor controller. An SPI master selects it by pulling `spi_csn` low and clocks in 24-bit words, most significant bit first, sampled on rising `spi_sclk` edges. The last 24 bits held when the select line returns high form the command: a 4-bit opcode in bits 23..20, a 4-bit address in bits 19..16 and a 16-bit data field in bits 15..0. The fields are presented to the rest of the chip together with a single-cycle execute strobe. The strobe is withheld for short frames, for the no-operation opcode, and while the nonvolatile store controller reports that it is busy.

The serial pins are treated as asynchronous. They are synchronised into the system clock domain, and clock edges are found by oversampling, so the SPI clock must be several times slower than `clk`. Both common SPI modes that capture on the rising edge work: clock idle low and clock idle high. The outgoing line repeats the received bit stream 24 clocks later, so several devices can be daisy-chained. After a read opcode, the data field of the outgoing word is replaced by a value supplied by the neighbouring blocks, and the next frame shifts that value out. The output enable models the open-drain driver. It is active only while the device is selected.

Top module: `spi_cmd_frontend`

## Requirements
- R1: A frame is captured MSB first on rising SCLK edges. The opcode is taken from bits 23..20, the address from bits 19..16 and the data from bits 15..0, and these appear on `cmd_op`, `cmd_addr` and `cmd_data`.
- R2: `cmd_exec` pulses for exactly one clock, and only after chip-select has returned high. It is never raised while the device is selected. The command outputs change only together with that pulse.
- R3: When more than 24 bits are clocked in one frame, the last 24 bits received form the command.
- R4: A frame of fewer than 24 bits produces no `cmd_exec`, and the command outputs keep their values.
- R5: While selected, `sdo` presents the bit that was received 24 rising SCLK edges earlier, counted across frame boundaries.
- R6: After an executed opcode 9 or opcode 10, bits 15..0 of the outgoing word are replaced by `rd_data`, captured in the clock after `cmd_exec`. Bits 23..16 keep the received opcode and address, and the next frame shifts the whole word out on `sdo`.
- R7: `sdo_oe` is high while the synchronised chip-select is low and low otherwise. It is 0 out of reset.
- R8: While `store_busy` is high at the moment chip-select rises, no `cmd_exec` is issued and no readback load takes place.
- R9: Opcode 0 is a no-operation. It produces no `cmd_exec` and leaves the command outputs unchanged.
- R10: After reset, `cmd_exec` is 0, the command outputs are 0, `sdo_oe` is 0 and the outgoing word is all zeros.
- R11: SCLK edges while chip-select is high are ignored. They do not shift the outgoing word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | Serial clock from the master |
| spi_sdi | input | 1 | Serial data in, MSB first |
| spi_csn | input | 1 | Chip-select, active low |
| store_busy | input | 1 | Lock from the nonvolatile store controller; suppresses execution |
| rd_data | input | 16 | Readback value for the held opcode and address |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable of `sdo` (models the open-drain driver) |
| cmd_exec | output | 1 | One-cycle execute strobe |
| cmd_op | output | 4 | Held opcode |
| cmd_addr | output | 4 | Held address |
| cmd_data | output | 16 | Held data field |

## Verification
Two functions act on the same outgoing shift register: the readback load and the daisy-chain delay line. A read frame executes when chip-select rises, and the following frame starts shifting that register out on `sdo`. The bench provokes this with back-to-back frames: a read of the wiper, then a no-operation, then a read of the stored word followed by a short frame. Each time, the captured `sdo` stream must show the received opcode and address in the upper byte and the readback value in the lower 16 bits. A locked read frame checks the other side: there the delay line must carry the raw received word, with no readback load.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

    localparam int unsigned CMD_OP_W   = 4;
    localparam int unsigned CMD_ADDR_W = 4;
    localparam int unsigned CMD_DATA_W = 16;
    localparam int unsigned CMD_WORD_W = CMD_OP_W + CMD_ADDR_W + CMD_DATA_W;
    localparam int unsigned CMD_CNT_W  = $clog2(CMD_WORD_W + 1);

    localparam logic [CMD_OP_W-1:0] OP_NOP      = 4'd0;
    localparam logic [CMD_OP_W-1:0] OP_RD_STORE = 4'd9;
    localparam logic [CMD_OP_W-1:0] OP_RD_WIPER = 4'd10;

    typedef struct packed {
        logic [CMD_OP_W-1:0]   op;
        logic [CMD_ADDR_W-1:0] addr;
        logic [CMD_DATA_W-1:0] data;
    } cmd_fields_t;

    typedef struct packed {
        logic                  sclk_prev;
        logic                  csn_prev;
        logic [CMD_WORD_W-1:0] shift;
        logic [CMD_CNT_W-1:0]  cnt;
        logic                  exec;
        logic                  load_pend;
        cmd_fields_t           cmd;
    } core_state_t;

endpackage

// File: rtl/spi_cmd_sync.sv
module spi_cmd_sync #(
    parameter int unsigned    W       = 3,
    parameter int unsigned    STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= RST_VAL;
                else        stage_q[g] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= RST_VAL;
                else        stage_q[g] <= stage_q[g-1];
            end
        end
    end

    assign q = stage_q[STAGES-1];

endmodule

// File: rtl/spi_cmd_decode.sv
module spi_cmd_decode
    import spi_cmd_pkg::*;
(
    input  logic [CMD_WORD_W-1:0] word,
    output cmd_fields_t           fields,
    output logic                  is_read,
    output logic                  is_nop
);

    always_comb begin
        fields  = cmd_fields_t'(word);
        is_read = (fields.op == OP_RD_STORE) || (fields.op == OP_RD_WIPER);
        is_nop  = (fields.op == OP_NOP);
    end

endmodule

// File: rtl/spi_cmd_frontend.sv
module spi_cmd_frontend
    import spi_cmd_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  spi_sclk,
    input  logic                  spi_sdi,
    input  logic                  spi_csn,
    input  logic                  store_busy,
    input  logic [CMD_DATA_W-1:0] rd_data,
    output logic                  sdo,
    output logic                  sdo_oe,
    output logic                  cmd_exec,
    output logic [CMD_OP_W-1:0]   cmd_op,
    output logic [CMD_ADDR_W-1:0] cmd_addr,
    output logic [CMD_DATA_W-1:0] cmd_data
);

    localparam logic [CMD_CNT_W-1:0] FULL_CNT = CMD_CNT_W'(CMD_WORD_W);

    logic [2:0]  pins_raw;
    logic [2:0]  pins_s;
    logic        csn_s;
    logic        sclk_s;
    logic        sdi_s;
    logic        sclk_rise;
    logic        cs_rise;
    cmd_fields_t rx_fields;
    logic        rx_read;
    logic        rx_nop;
    core_state_t st_d;
    core_state_t st_q;

    assign pins_raw = {spi_csn, spi_sclk, spi_sdi};

    spi_cmd_sync #(
        .W       (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b100)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pins_raw),
        .q     (pins_s)
    );

    assign csn_s  = pins_s[2];
    assign sclk_s = pins_s[1];
    assign sdi_s  = pins_s[0];

    spi_cmd_decode u_dec (
        .word    (st_q.shift),
        .fields  (rx_fields),
        .is_read (rx_read),
        .is_nop  (rx_nop)
    );

    always_comb begin
        st_d           = st_q;
        st_d.exec      = 1'b0;
        st_d.load_pend = 1'b0;
        st_d.sclk_prev = sclk_s;
        st_d.csn_prev  = csn_s;

        sclk_rise = sclk_s & ~st_q.sclk_prev;
        cs_rise   = csn_s & ~st_q.csn_prev;

        // bit capture while selected; counter saturates at one full word
        if (csn_s) begin
            st_d.cnt = '0;
        end else if (sclk_rise) begin
            st_d.shift = {st_q.shift[CMD_WORD_W-2:0], sdi_s};
            if (st_q.cnt != FULL_CNT) begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end

        // execute decision on deselect
        if (cs_rise && (st_q.cnt == FULL_CNT) && !store_busy && !rx_nop) begin
            st_d.exec      = 1'b1;
            st_d.cmd       = rx_fields;
            st_d.load_pend = rx_read;
        end

        // readback replaces the data field of the outgoing word
        if (st_q.load_pend) begin
            st_d.shift[CMD_DATA_W-1:0] = rd_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q           <= '0;
            st_q.sclk_prev <= 1'b0;
            st_q.csn_prev  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign sdo      = st_q.shift[CMD_WORD_W-1];
    assign sdo_oe   = ~csn_s;
    assign cmd_exec = st_q.exec;
    assign cmd_op   = st_q.cmd.op;
    assign cmd_addr = st_q.cmd.addr;
    assign cmd_data = st_q.cmd.data;

endmodule

// File: rtl/spi_cmd_frontend_chk.sv
module spi_cmd_frontend_chk
    import spi_cmd_pkg::*;
(
    input logic                  clk,
    input logic                  rst_n,
    input logic                  store_busy,
    input logic                  sdo,
    input logic                  sdo_oe,
    input logic                  cmd_exec,
    input logic [CMD_OP_W-1:0]   cmd_op,
    input logic [CMD_ADDR_W-1:0] cmd_addr,
    input logic [CMD_DATA_W-1:0] cmd_data
);

    p_exec_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_exec |=> !cmd_exec);

    p_exec_deselected_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_exec |-> !sdo_oe);

    p_fields_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_exec |-> $stable({cmd_op, cmd_addr, cmd_data}));

    p_lock_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_exec |-> !$past(store_busy));

    p_nop_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_exec |-> (cmd_op != OP_NOP));

    p_idle_sdo_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!sdo_oe && !$past(sdo_oe) && !$past(cmd_exec)) |-> $stable(sdo));

endmodule

bind spi_cmd_frontend spi_cmd_frontend_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .store_busy (store_busy),
    .sdo        (sdo),
    .sdo_oe     (sdo_oe),
    .cmd_exec   (cmd_exec),
    .cmd_op     (cmd_op),
    .cmd_addr   (cmd_addr),
    .cmd_data   (cmd_data)
);

// File: tb/spi_cmd_frontend_tb.sv
module spi_cmd_frontend_tb;

    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        spi_sclk = 1'b0;
    logic        spi_sdi = 1'b0;
    logic        spi_csn = 1'b1;
    logic        store_busy = 1'b0;
    logic [15:0] rd_data;
    logic        sdo;
    logic        sdo_oe;
    logic        cmd_exec;
    logic [3:0]  cmd_op;
    logic [3:0]  cmd_addr;
    logic [15:0] cmd_data;

    int checks = 0;
    int errors = 0;

    logic [23:0] exp_q[$];
    logic [23:0] model_sh = '0;
    logic [23:0] last_cmd = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_cmd_frontend u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .spi_sclk   (spi_sclk),
        .spi_sdi    (spi_sdi),
        .spi_csn    (spi_csn),
        .store_busy (store_busy),
        .rd_data    (rd_data),
        .sdo        (sdo),
        .sdo_oe     (sdo_oe),
        .cmd_exec   (cmd_exec),
        .cmd_op     (cmd_op),
        .cmd_addr   (cmd_addr),
        .cmd_data   (cmd_data)
    );

    function automatic logic [15:0] rd_model(input logic [3:0] op, input logic [3:0] addr);
        if (op == 4'd9)       return 16'h5A00 | {12'h0, addr};
        else if (op == 4'd10) return 16'h0300 | {12'h0, addr};
        else                  return 16'hFFFF;
    endfunction

    always_comb rd_data = rd_model(cmd_op, cmd_addr);

    task automatic chk(input bit ok, input string req, input logic [47:0] act, input logic [47:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: pops expected commands as execute strobes appear
    always @(negedge clk) begin
        if (rst_n && cmd_exec) begin
            chk(spi_csn == 1'b1, "R2", {47'h0, spi_csn}, 48'h1);
            if (exp_q.size() == 0) begin
                chk(1'b0, "R1", {24'h0, cmd_op, cmd_addr, cmd_data}, 48'h0);
            end else begin
                logic [23:0] e;
                e = exp_q.pop_front();
                chk({cmd_op, cmd_addr, cmd_data} == e, "R1",
                    {24'h0, cmd_op, cmd_addr, cmd_data}, {24'h0, e});
            end
        end
    end

    task automatic run_frame(input logic [47:0] bits, input int n, input bit mode3,
                             input bit lock, input string sdo_tag, input string fld_tag);
        logic [47:0] seen;
        logic [47:0] expv;
        logic [71:0] stream;
        seen = '0;
        expv = '0;
        stream = {model_sh, bits};
        store_busy = lock;
        if (mode3) begin
            spi_sclk = 1'b1;
            repeat (4) @(negedge clk);
        end
        spi_csn = 1'b0;
        repeat (6) @(negedge clk);
        chk(sdo_oe == 1'b1, "R7", {47'h0, sdo_oe}, 48'h1);
        for (int i = 0; i < n; i++) begin
            spi_sclk = 1'b0;
            spi_sdi  = bits[n-1-i];
            repeat (4) @(negedge clk);
            seen[n-1-i] = sdo;
            spi_sclk = 1'b1;
            repeat (4) @(negedge clk);
        end
        if (!mode3) spi_sclk = 1'b0;
        // expected outgoing stream: old word MSB first, then this frame's bits
        for (int i = 0; i < n; i++) begin
            if (i < 24) expv[n-1-i] = model_sh[23-i];
            else        expv[n-1-i] = bits[n-1-(i-24)];
        end
        for (int i = 0; i < n; i++) model_sh = {model_sh[22:0], bits[n-1-i]};
        if (n >= 24 && !lock && model_sh[23:20] != 4'd0) begin
            exp_q.push_back(model_sh);
            last_cmd = model_sh;
            if (model_sh[23:20] == 4'd9 || model_sh[23:20] == 4'd10)
                model_sh[15:0] = rd_model(model_sh[23:20], model_sh[19:16]);
        end
        repeat (2) @(negedge clk);
        spi_csn = 1'b1;
        repeat (12) @(negedge clk);
        store_busy = 1'b0;
        chk(seen == expv, sdo_tag, seen, expv);
        chk(sdo_oe == 1'b0, "R7", {47'h0, sdo_oe}, 48'h0);
        chk({cmd_op, cmd_addr, cmd_data} == last_cmd, fld_tag,
            {24'h0, cmd_op, cmd_addr, cmd_data}, {24'h0, last_cmd});
        if (stream == '1) $display("unused");
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        chk(1'b0, "watchdog", 48'h0, 48'h1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R10: reset state
        chk(cmd_exec == 1'b0, "R10", {47'h0, cmd_exec}, 48'h0);
        chk({cmd_op, cmd_addr, cmd_data} == 24'h0, "R10", {24'h0, cmd_op, cmd_addr, cmd_data}, 48'h0);
        chk(sdo_oe == 1'b0, "R10", {47'h0, sdo_oe}, 48'h0);
        chk(sdo == 1'b0, "R10", {47'h0, sdo}, 48'h0);

        // R1 / R5: write wiper, clock idle low; outgoing stream is the reset word
        run_frame(48'hB00100, 24, 1'b0, 1'b0, "R5", "R1");
        // R5: clock idle high; previous word must come back
        run_frame(48'h21ABCD, 24, 1'b1, 1'b0, "R5", "R1");
        // R3: 48-bit frame, the last 24 bits form the command
        run_frame(48'h3333334E1234, 48, 1'b0, 1'b0, "R5", "R3");
        // R6: wiper read, then a NOP frame shifts out the readback (R9)
        run_frame(48'hA30000, 24, 1'b0, 1'b0, "R5", "R1");
        run_frame(48'h000000, 24, 1'b0, 1'b0, "R6", "R9");
        // R6: stored-word read, then a short frame (R4)
        run_frame(48'h95FFFF, 24, 1'b1, 1'b0, "R5", "R1");
        run_frame(48'h2A5, 10, 1'b0, 1'b0, "R6", "R4");
        // R8: locked write and locked read: no strobe, no readback load
        run_frame(48'hB10222, 24, 1'b0, 1'b1, "R5", "R8");
        run_frame(48'hA10000, 24, 1'b0, 1'b1, "R5", "R8");
        run_frame(48'hE00000, 24, 1'b0, 1'b0, "R8", "R1");
        // R11: clock edges while deselected are ignored
        for (int k = 0; k < 5; k++) begin
            spi_sclk = 1'b1;
            repeat (4) @(negedge clk);
            spi_sclk = 1'b0;
            repeat (4) @(negedge clk);
        end
        run_frame(48'hF00001, 24, 1'b0, 1'b0, "R11", "R1");

        chk(exp_q.size() == 0, "R2", 48'(exp_q.size()), 48'h0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule